// File: doc/BRIEF.md
# Capture/Compare Counter Array

The block is a set of capture/compare channels that share one free-running 16-bit timebase. The timebase advances on one of four tick sources: a slow prescale of the system clock, a fast prescale of the system clock, an overflow pulse from another timer, or rising edges on an external count pin. A run bit gates the timebase, and an idle-freeze bit stops it while the system reports idle. When the count wraps from FFFFh to 0000h, it sets an overflow flag.

Each channel has a 7-bit mode register and a 16-bit compare/capture register, which is split into a low byte and a high byte. Depending on its mode, a channel does one of the following:
- stamps the count when its input pin rises, falls, or does either;
- raises a flag when the count reaches the compare value, and can also invert its output pin on that match;
- drives an 8-bit PWM output, whose duty value reloads when the low byte of the count rolls over;
- in the last channel only, requests a chip reset on a compare match.

Software reaches all of this through a byte-wide register port. The sticky flags drive one combined interrupt.

Register map (byte addresses):
- 0: control. Bit 0 is run, bit 1 is idle-freeze, bits 3:2 are the source select, bit 4 is the watchdog enable, and bit 5 is the overflow interrupt enable.
- 1: flags. Bit 0 is the overflow flag, and bit k+1 is the flag of channel k.
- 2 and 3: count low byte and count high byte.
- 8+4k: mode register of channel k.
- 9+4k and 10+4k: compare low byte and compare high byte of channel k.

Reads return their data one clock after the address is presented.

Top module: `cca_array`

## Requirements
- R1: Control bits 3:2 pick the tick source. A value of 0 ticks once every 12 clocks. A value of 1 ticks once every 4 clocks. A value of 2 ticks on each cycle the timer-overflow input is high. A value of 3 ticks on each rising edge of the external count pin.
- R2: The count advances only while run (control bit 0) is set. It also holds while idle is high and idle-freeze (control bit 1) is set. A tick at FFFFh wraps the count to 0000h and sets flag bit 0. A write to a count byte takes priority over a tick in the same cycle.
- R3: The mode bits are laid out as follows: bit 6 compare enable, bit 5 capture on rising edge, bit 4 capture on falling edge, bit 3 match, bit 2 toggle, bit 1 PWM, bit 0 interrupt enable.
- R4: A selected edge on a channel's input pin copies the current count into that channel's compare bytes and sets the channel's flag.
- R5: A write to a channel's compare low byte clears its compare enable bit. A write to its compare high byte sets that bit.
- R6: If compare enable and match are both set and PWM is clear, the count advancing to the compare value sets the channel flag. If toggle is also set, the channel output inverts.
- R7: When PWM and compare enable are both set, the channel output is 0 while the low count byte is below the compare low byte, and 1 otherwise. The output is registered, so it lags the count by one clock.
- R8: In PWM mode, a tick that rolls the low count byte from FFh to 00h loads the compare high byte into the compare low byte.
- R9: If watchdog enable (control bit 4) is set, a compare match on the last channel pulses the reset request for one clock. Matches on any other channel never do this.
- R10: The interrupt output goes high one clock after any flag is set while its enable is set. Channel flags use mode bit 0 as their enable. The overflow flag uses control bit 5.
- R11: Each flag stays set until software writes a 0 to it. A hardware event in the same cycle as that write takes priority, so the flag stays set.
- R12: After reset, every register reads as 0, and the interrupt, reset request and channel outputs are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idle | input | 1 | System idle indication |
| tmr_ovf | input | 1 | Overflow pulse from another timer |
| ext_in | input | 1 | External count pin |
| cap_in | input | N_CH | Channel input pins |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ch_out | output | N_CH | Channel output pins |
| irq | output | 1 | Combined interrupt |
| wdog_rst | output | 1 | Watchdog reset request pulse |

## Verification
The timebase is driven from each of its four sources in turn, so a wrong source decode shows up as a different count. The pulsed sources give exact, hand-computable counts, and these separate gating by run and idle from normal ticking. Rising, falling and both-edge pin patterns on separate channels reveal whether the edge polarity of a capture is swapped. Compare tests land the count exactly on the compare value, including a flag clear written in the very cycle of a match. A long prescaled run then sweeps the PWM through several low-byte rollovers, so the duty reload is exercised as well as the basic compare.

// File: rtl/cca_pkg.sv
package cca_pkg;
  // register byte addresses
  localparam int CTRL_A    = 0;
  localparam int FLAG_A    = 1;
  localparam int CNTL_A    = 2;
  localparam int CNTH_A    = 3;
  localparam int CH_BASE   = 8;
  localparam int CH_STRIDE = 4;
  // control bits
  localparam int CB_RUN  = 0;
  localparam int CB_IFRZ = 1;
  localparam int CB_SRC  = 2;
  localparam int CB_WDEN = 4;
  localparam int CB_OVIE = 5;
  localparam int CTRL_W  = 6;
  // mode bits
  localparam int MB_ECOM = 6;
  localparam int MB_CAPP = 5;
  localparam int MB_CAPN = 4;
  localparam int MB_MAT  = 3;
  localparam int MB_TOG  = 2;
  localparam int MB_PWM  = 1;
  localparam int MB_IE   = 0;
  localparam int MODE_W  = 7;

  typedef enum logic [1:0] {
    SRC_SLOW = 2'd0,
    SRC_FAST = 2'd1,
    SRC_TMR  = 2'd2,
    SRC_PIN  = 2'd3
  } src_e;
endpackage

// File: rtl/cca_timebase.sv
module cca_timebase
  import cca_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int DIV_SLOW = 12,
  parameter int DIV_FAST = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  src_e             src,
  input  logic             gate,
  input  logic             tmr_ovf,
  input  logic             ext_in,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [7:0]       wdata,
  output logic [CNT_W-1:0] cnt,
  output logic             adv,
  output logic             wrap,
  output logic             lo_roll
);
  localparam int SW = $clog2(DIV_SLOW);
  localparam int FW = $clog2(DIV_FAST);
  localparam int HB = CNT_W - 8;

  logic [SW-1:0] pre_s;
  logic [FW-1:0] pre_f;
  logic          ext_q;
  logic          tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_s <= '0;
      pre_f <= '0;
      ext_q <= 1'b0;
    end else begin
      pre_s <= (pre_s == SW'(DIV_SLOW - 1)) ? '0 : pre_s + SW'(1);
      pre_f <= (pre_f == FW'(DIV_FAST - 1)) ? '0 : pre_f + FW'(1);
      ext_q <= ext_in;
    end
  end

  always_comb begin
    unique case (src)
      SRC_SLOW: tick = (pre_s == SW'(DIV_SLOW - 1));
      SRC_FAST: tick = (pre_f == FW'(DIV_FAST - 1));
      SRC_TMR:  tick = tmr_ovf;
      default:  tick = ext_in & ~ext_q;
    endcase
  end

  assign adv     = tick & gate & ~wr_lo & ~wr_hi;
  assign wrap    = adv & (&cnt);
  assign lo_roll = adv & (&cnt[7:0]);

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (wr_lo) cnt[7:0] <= wdata;
    else if (wr_hi) cnt[CNT_W-1:8] <= wdata[HB-1:0];
    else if (adv) cnt <= cnt + CNT_W'(1);
  end

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!gate && !wr_lo && !wr_hi) |=> $stable(cnt));
  // R2
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cnt == '0));
endmodule

// File: rtl/cca_channel.sv
module cca_channel
  import cca_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter bit WDOG_CAP  = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_mode,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [7:0]        wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              adv,
  input  logic              lo_roll,
  input  logic              pin,
  input  logic              wdog_en,
  output logic [MODE_W-1:0] mode,
  output logic [7:0]        cap_lo,
  output logic [7:0]        cap_hi,
  output logic              evt,
  output logic              out_pin,
  output logic              wdog_hit
);
  localparam int HB = CNT_W - 8;

  logic             pin_q;
  logic             rise, fall, cap_evt, pwm_on, match_evt;
  logic [CNT_W-1:0] cnt_inc;

  assign cnt_inc   = cnt + CNT_W'(1);
  assign rise      = pin & ~pin_q;
  assign fall      = ~pin & pin_q;
  assign cap_evt   = (mode[MB_CAPP] & rise) | (mode[MB_CAPN] & fall);
  assign pwm_on    = mode[MB_PWM] & mode[MB_ECOM];
  assign match_evt = adv & mode[MB_ECOM] & mode[MB_MAT] & ~mode[MB_PWM]
                     & (cnt_inc == {cap_hi[HB-1:0], cap_lo});
  assign evt       = cap_evt | match_evt;
  assign wdog_hit  = WDOG_CAP & wdog_en & match_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q   <= 1'b0;
      mode    <= '0;
      cap_lo  <= '0;
      cap_hi  <= '0;
      out_pin <= 1'b0;
    end else begin
      pin_q <= pin;
      if (wr_mode)    mode <= wdata[MODE_W-1:0];
      else if (wr_lo) mode[MB_ECOM] <= 1'b0;
      else if (wr_hi) mode[MB_ECOM] <= 1'b1;

      if (cap_evt)                 cap_lo <= cnt[7:0];
      else if (wr_lo)              cap_lo <= wdata;
      else if (lo_roll && pwm_on)  cap_lo <= cap_hi;

      if (cap_evt)    cap_hi <= 8'(cnt[CNT_W-1:8]);
      else if (wr_hi) cap_hi <= wdata;

      if (pwm_on)                          out_pin <= (cnt[7:0] >= cap_lo);
      else if (match_evt && mode[MB_TOG])  out_pin <= ~out_pin;
    end
  end

  // R5
  lo_clr_chk: assert property (@(posedge clk) disable iff (rst)
    wr_lo |=> !mode[MB_ECOM]);
  // R5
  hi_set_chk: assert property (@(posedge clk) disable iff (rst)
    wr_hi |=> mode[MB_ECOM]);
  // R4
  cap_val_chk: assert property (@(posedge clk) disable iff (rst)
    cap_evt |=> ({cap_hi[HB-1:0], cap_lo} == $past(cnt)));
  // R6
  tog_chk: assert property (@(posedge clk) disable iff (rst)
    (match_evt && mode[MB_TOG]) |=> (out_pin != $past(out_pin)));
endmodule

// File: rtl/cca_array.sv
module cca_array
  import cca_pkg::*;
#(
  parameter int N_CH     = 5,
  parameter int CNT_W    = 16,
  parameter int ADDR_W   = 6,
  parameter int DIV_SLOW = 12,
  parameter int DIV_FAST = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              idle,
  input  logic              tmr_ovf,
  input  logic              ext_in,
  input  logic [N_CH-1:0]   cap_in,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic [N_CH-1:0]   ch_out,
  output logic              irq,
  output logic              wdog_rst
);
  localparam int FL_W = N_CH + 1;

  logic [CTRL_W-1:0] ctrl;
  logic [FL_W-1:0]   flags, flags_n;
  logic [CNT_W-1:0]  cnt;
  logic              adv, wrap, lo_roll, gate;
  logic              wr_cl, wr_ch;
  logic [N_CH-1:0]   evt, wd_hit, ie;
  logic [MODE_W-1:0] mode_a [N_CH];
  logic [7:0]        lo_a   [N_CH];
  logic [7:0]        hi_a   [N_CH];
  logic [7:0]        rd_n;

  assign gate  = ctrl[CB_RUN] & ~(idle & ctrl[CB_IFRZ]);
  assign wr_cl = bus_we && (bus_addr == ADDR_W'(CNTL_A));
  assign wr_ch = bus_we && (bus_addr == ADDR_W'(CNTH_A));

  cca_timebase #(.CNT_W(CNT_W), .DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_tb (
    .clk(clk), .rst(rst), .src(src_e'(ctrl[CB_SRC+:2])), .gate(gate),
    .tmr_ovf(tmr_ovf), .ext_in(ext_in), .wr_lo(wr_cl), .wr_hi(wr_ch),
    .wdata(bus_wdata), .cnt(cnt), .adv(adv), .wrap(wrap), .lo_roll(lo_roll)
  );

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    localparam int BA = CH_BASE + CH_STRIDE * k;
    cca_channel #(.CNT_W(CNT_W), .WDOG_CAP(k == N_CH - 1)) u_ch (
      .clk(clk), .rst(rst),
      .wr_mode(bus_we && (bus_addr == ADDR_W'(BA))),
      .wr_lo(bus_we && (bus_addr == ADDR_W'(BA + 1))),
      .wr_hi(bus_we && (bus_addr == ADDR_W'(BA + 2))),
      .wdata(bus_wdata), .cnt(cnt), .adv(adv), .lo_roll(lo_roll),
      .pin(cap_in[k]), .wdog_en(ctrl[CB_WDEN]),
      .mode(mode_a[k]), .cap_lo(lo_a[k]), .cap_hi(hi_a[k]),
      .evt(evt[k]), .out_pin(ch_out[k]), .wdog_hit(wd_hit[k])
    );
    assign ie[k] = mode_a[k][MB_IE];
  end

  always_comb begin
    flags_n = flags;
    if (bus_we && (bus_addr == ADDR_W'(FLAG_A))) flags_n = bus_wdata[FL_W-1:0];
    flags_n = flags_n | {evt, wrap};
  end

  always_comb begin
    rd_n = '0;
    if (bus_addr == ADDR_W'(CTRL_A)) rd_n = 8'(ctrl);
    if (bus_addr == ADDR_W'(FLAG_A)) rd_n = 8'(flags);
    if (bus_addr == ADDR_W'(CNTL_A)) rd_n = cnt[7:0];
    if (bus_addr == ADDR_W'(CNTH_A)) rd_n = 8'(cnt[CNT_W-1:8]);
    for (int k = 0; k < N_CH; k++) begin
      if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * k))     rd_n = 8'(mode_a[k]);
      if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * k + 1)) rd_n = lo_a[k];
      if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * k + 2)) rd_n = hi_a[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl      <= '0;
      flags     <= '0;
      bus_rdata <= '0;
      irq       <= 1'b0;
      wdog_rst  <= 1'b0;
    end else begin
      if (bus_we && (bus_addr == ADDR_W'(CTRL_A))) ctrl <= bus_wdata[CTRL_W-1:0];
      flags     <= flags_n;
      bus_rdata <= rd_n;
      irq       <= (|(flags[FL_W-1:1] & ie)) | (flags[0] & ctrl[CB_OVIE]);
      wdog_rst  <= |wd_hit;
    end
  end

  // R11
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    (|evt) |=> ((flags[FL_W-1:1] & $past(evt)) == $past(evt)));
  // R2
  ovf_flag_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |=> flags[0]);
  // R9
  wdog_en_chk: assert property (@(posedge clk) disable iff (rst)
    wdog_rst |-> $past(ctrl[CB_WDEN]));
  // R10
  irq_chk: assert property (@(posedge clk) disable iff (rst)
    (|(flags[FL_W-1:1] & ie)) |=> irq);
endmodule

// File: tb/sim_cca_array.sv
`timescale 1ns/1ps
module sim_cca_array;
  localparam int N = 5;
  localparam int AW = 6;
  localparam int MAXCYC = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic idle = 1'b0, tmr_ovf = 1'b0, ext_in = 1'b0;
  logic [N-1:0] cap_in = '0;
  logic bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  wire  [7:0] bus_rdata;
  wire  [N-1:0] ch_out;
  wire  irq, wdog_rst;

  always #2 clk = ~clk;

  cca_array #(.N_CH(N), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .idle(idle), .tmr_ovf(tmr_ovf), .ext_in(ext_in),
    .cap_in(cap_in), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ch_out(ch_out), .irq(irq), .wdog_rst(wdog_rst));

  int checks = 0, errors = 0, cyc = 0;
  string ph = "R12";
  logic last_wd = 1'b0;

  // behavioural reference state
  logic [15:0] m_cnt;
  int m_p12, m_p4;
  logic m_extp;
  logic [5:0] m_ctrl;
  logic [7:0] m_flag;
  logic [6:0] m_mode [N];
  logic [7:0] m_lo [N];
  logic [7:0] m_hi [N];
  logic [N-1:0] m_out, m_pin;
  logic m_irq, m_wdr;
  logic [7:0] m_rd;

  function automatic logic [7:0] m_read(int a);
    logic [7:0] r = 8'h00;
    if (a == 0) r = {2'b00, m_ctrl};
    if (a == 1) r = m_flag;
    if (a == 2) r = m_cnt[7:0];
    if (a == 3) r = m_cnt[15:8];
    for (int k = 0; k < N; k++) begin
      if (a == 8 + 4*k) r = {1'b0, m_mode[k]};
      if (a == 9 + 4*k) r = m_lo[k];
      if (a == 10 + 4*k) r = m_hi[k];
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_p12 = 0; m_p4 = 0; m_extp = 0; m_ctrl = 0; m_flag = 0;
      m_out = 0; m_pin = 0; m_irq = 0; m_wdr = 0; m_rd = 0;
      for (int k = 0; k < N; k++) begin m_mode[k] = 0; m_lo[k] = 0; m_hi[k] = 0; end
    end else begin
      int a;
      bit tick, gate, cw, adv, wd, anyf;
      logic [7:0] nf;
      logic [N-1:0] ev;
      a = int'(bus_addr);
      case (m_ctrl[3:2])
        2'd0: tick = (m_p12 == 11);
        2'd1: tick = (m_p4 == 3);
        2'd2: tick = tmr_ovf;
        default: tick = ext_in && !m_extp;
      endcase
      m_p12 = (m_p12 + 1) % 12;
      m_p4  = (m_p4 + 1) % 4;
      m_extp = ext_in;
      gate = m_ctrl[0] && !(idle && m_ctrl[1]);
      cw = bus_we && (a == 2 || a == 3);
      adv = tick && gate && !cw;
      m_rd = m_read(a);
      anyf = m_flag[0] && m_ctrl[5];
      for (int k = 0; k < N; k++) if (m_flag[k+1] && m_mode[k][0]) anyf = 1;
      m_irq = anyf;
      wd = 0;
      for (int k = 0; k < N; k++) begin
        bit rise, fall, cap, pwm, mt;
        logic [7:0] nlo, nhi;
        logic [6:0] nm;
        logic no;
        rise = cap_in[k] && !m_pin[k];
        fall = !cap_in[k] && m_pin[k];
        cap = (m_mode[k][5] && rise) || (m_mode[k][4] && fall);
        pwm = m_mode[k][1] && m_mode[k][6];
        mt = adv && m_mode[k][6] && m_mode[k][3] && !m_mode[k][1]
             && (16'(m_cnt + 16'd1) == {m_hi[k], m_lo[k]});
        no = pwm ? (m_cnt[7:0] >= m_lo[k]) : ((mt && m_mode[k][2]) ? !m_out[k] : m_out[k]);
        if (cap) nlo = m_cnt[7:0];
        else if (bus_we && a == 9 + 4*k) nlo = bus_wdata;
        else if (adv && m_cnt[7:0] == 8'hFF && pwm) nlo = m_hi[k];
        else nlo = m_lo[k];
        if (cap) nhi = m_cnt[15:8];
        else if (bus_we && a == 10 + 4*k) nhi = bus_wdata;
        else nhi = m_hi[k];
        nm = m_mode[k];
        if (bus_we && a == 8 + 4*k) nm = bus_wdata[6:0];
        else if (bus_we && a == 9 + 4*k) nm[6] = 1'b0;
        else if (bus_we && a == 10 + 4*k) nm[6] = 1'b1;
        ev[k] = cap || mt;
        if (k == N-1 && m_ctrl[4] && mt) wd = 1;
        m_mode[k] = nm; m_lo[k] = nlo; m_hi[k] = nhi; m_out[k] = no;
        m_pin[k] = cap_in[k];
      end
      nf = (bus_we && a == 1) ? {2'b00, bus_wdata[5:0]} : m_flag;
      if (adv && m_cnt == 16'hFFFF) nf[0] = 1'b1;
      for (int k = 0; k < N; k++) if (ev[k]) nf[k+1] = 1'b1;
      m_flag = nf;
      m_wdr = wd;
      if (bus_we && a == 0) m_ctrl = bus_wdata[5:0];
      if (bus_we && a == 2) m_cnt[7:0] = bus_wdata;
      else if (bus_we && a == 3) m_cnt[15:8] = bus_wdata;
      else if (adv) m_cnt = m_cnt + 16'd1;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // every-clock comparison against the reference, away from the edge
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      chk({ph, " rdata"}, int'(bus_rdata), int'(m_rd));
      chk({ph, " ch_out"}, int'(ch_out), int'(m_out));
      chk({ph, " irq (R10)"}, int'(irq), int'(m_irq));
      chk({ph, " wdog (R9)"}, int'(wdog_rst), int'(m_wdr));
    end
  end

  task automatic wr(int a, int d);
    bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = 8'(d);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(int a, output int v);
    bus_addr = AW'(a);
    @(negedge clk);
    v = int'(bus_rdata);
  endtask

  task automatic pulse();
    tmr_ovf = 1'b1;
    @(negedge clk);
    tmr_ovf = 1'b0;
    last_wd = wdog_rst;
  endtask

  task automatic idle_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(MAXCYC * 4);
    errors++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v;
    idle_cyc(3);
    @(negedge clk); rst = 1'b0;
    // R12: reset state
    ph = "R12";
    rd(0, v); chk("R12 ctrl", v, 0);
    rd(1, v); chk("R12 flags", v, 0);
    rd(2, v); chk("R12 cnt lo", v, 0);
    chk("R12 outputs", int'({ch_out, irq, wdog_rst}), 0);

    // R1: sources
    ph = "R1";
    wr(0, 8'h09);
    for (int i = 0; i < 7; i++) pulse();
    rd(2, v); chk("R1 timer pulses", v, 7);
    wr(0, 8'h0D);
    for (int i = 0; i < 5; i++) begin ext_in = 1; idle_cyc(2); ext_in = 0; idle_cyc(2); end
    rd(2, v); chk("R1 pin edges", v, 12);
    wr(0, 8'h05); idle_cyc(41);
    rd(2, v); chk("R1 fast prescale", v, int'(m_rd));
    wr(0, 8'h01); idle_cyc(61);
    rd(2, v); chk("R1 slow prescale", v, int'(m_rd));

    // R2: gating and wrap
    ph = "R2";
    wr(2, 12); wr(3, 0);
    wr(0, 8'h08);
    for (int i = 0; i < 3; i++) pulse();
    rd(2, v); chk("R2 run clear holds", v, 12);
    wr(0, 8'h0B); idle = 1;
    for (int i = 0; i < 3; i++) pulse();
    rd(2, v); chk("R2 idle freeze holds", v, 12);
    idle = 0; pulse(); pulse();
    rd(2, v); chk("R2 runs after idle", v, 14);
    wr(0, 8'h09);
    wr(2, 8'hFE); wr(3, 8'hFF); pulse(); pulse();
    rd(3, v); chk("R2 wrap hi", v, 0);
    rd(1, v); chk("R2 overflow flag", v, 1);

    // R3/R4: capture edges
    ph = "R4";
    wr(1, 0);
    wr(8, 8'h20); wr(12, 8'h10); wr(16, 8'h31);
    rd(8, v); chk("R3 mode readback", v, 8'h20);
    wr(2, 8'h34); wr(3, 8'h12);
    cap_in[0] = 1; cap_in[1] = 1; cap_in[2] = 1; idle_cyc(2);
    rd(9, v);  chk("R4 rise capture lo", v, 8'h34);
    rd(14, v); chk("R4 neg channel ignores rise", v, 0);
    pulse();
    cap_in[0] = 0; cap_in[1] = 0; cap_in[2] = 0; idle_cyc(2);
    rd(9, v);  chk("R4 pos channel ignores fall", v, 8'h34);
    rd(13, v); chk("R4 fall capture lo", v, 8'h35);
    rd(18, v); chk("R4 both-edge capture hi", v, 8'h12);
    rd(1, v);  chk("R4 flags", v, 8'h0E);

    // R5: compare byte writes gate the comparator
    ph = "R5";
    wr(20, 8'h48); wr(21, 8'h40);
    rd(20, v); chk("R5 lo write clears enable", v, 8'h08);
    wr(22, 8'h12);
    rd(20, v); chk("R5 hi write sets enable", v, 8'h48);

    // R6: match and toggle
    ph = "R6";
    wr(20, 8'h4C); wr(21, 8'h40); wr(22, 8'h12);
    wr(1, 0);
    wr(2, 8'h35); wr(3, 8'h12);
    for (int i = 0; i < 11; i++) pulse();
    idle_cyc(1);
    chk("R6 toggle output", int'(ch_out[3]), 1);
    rd(1, v); chk("R6 match flag", v, 8'h10);

    // R11: clear racing a match
    ph = "R11";
    wr(1, 0);
    wr(2, 8'h3F);
    bus_we = 1; bus_addr = AW'(1); bus_wdata = 0; tmr_ovf = 1;
    @(negedge clk); bus_we = 0; tmr_ovf = 0;
    rd(1, v); chk("R11 event beats clear", v, 8'h10);
    idle_cyc(5);
    rd(1, v); chk("R11 flag sticky", v, 8'h10);
    wr(1, 0);
    rd(1, v); chk("R11 software clear", v, 0);

    // R9: watchdog only on last channel
    ph = "R9";
    wr(0, 8'h19);
    wr(24, 8'h48); wr(25, 8'h50); wr(26, 8'h12);
    wr(2, 8'h3F); pulse();
    chk("R9 non-last match no reset", int'(last_wd), 0);
    wr(2, 8'h4F); pulse();
    chk("R9 last channel reset pulse", int'(last_wd), 1);
    idle_cyc(1);
    chk("R9 pulse one clock", int'(wdog_rst), 0);

    // R10: interrupt
    ph = "R10";
    wr(0, 8'h09); wr(1, 0); idle_cyc(2);
    chk("R10 irq low", int'(irq), 0);
    cap_in[2] = 1; idle_cyc(3);
    chk("R10 channel irq", int'(irq), 1);
    wr(1, 0); idle_cyc(2);
    chk("R10 irq after clear", int'(irq), 0);
    wr(0, 8'h29); wr(2, 8'hFF); wr(3, 8'hFF); pulse(); idle_cyc(2);
    chk("R10 overflow irq", int'(irq), 1);

    // R7/R8: PWM and reload
    ph = "R7";
    wr(0, 8'h05); wr(1, 0);
    wr(9, 8'h40); wr(10, 8'h80); wr(8, 8'h42);
    idle_cyc(700);
    chk("R7 pwm output", int'(ch_out[0]), int'(m_out[0]));
    ph = "R8";
    idle_cyc(1500);
    rd(9, v); chk("R8 duty reloaded", v, 8'h80);
    idle_cyc(600);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule